// File: doc/BRIEF.md
# Sticky Alarm Status Controller

This block sits beside a data converter's sample path and gathers fault events from seven detectors in the data and clock logic. Each detector raises a one-cycle pulse. The block latches every pulse into its own sticky status bit, which holds until software clears it by writing a one to that bit. A mask register chooses which of the latched faults may drive a registered, active-high alarm pin.

A mute enable forces the outgoing sample stream to zero while any status bit is set, whether that bit is masked or not. Samples pass through unchanged again once software has cleared every bit. Software reaches the status, mask and control registers through a small port. That port has a write strobe, a 2-bit address and a 32-bit write bus, and its read data is combinational. Status is meaningful only after the converter is fully configured, so software is expected to clear all bits once the device runs.

Top module: `alarm_status_ctrl`

## Requirements
- R1: A pulse on `evt_i[k]` sets status bit k at the next rising clock edge. The bit positions are: 0 = FIFO empty, 1 = FIFO full, 2 = LVDS clock fault, 3 = LVDS strobe fault, 4 = trigger-clock realignment, 5 = clock realignment, 6 = clock alignment fault.
- R2: A set status bit stays set after its event goes low, until software clears it.
- R3: A write to address 0 (status) clears each status bit whose `wdata` bit is 1, at the next edge. A 0 in a `wdata` bit leaves that status bit unchanged.
- R4: If an event and a clearing write reach the same status bit in the same cycle, the bit ends set.
- R5: Address 1 holds the 7-bit mask, and a mask bit of 1 blocks that source. `alarm_o` is registered: it goes high one cycle after a set, unmasked status bit is present, and it is low when every set bit is masked.
- R6: Address 2, bit 0, is the mute enable. While it is 1 and any status bit is set (masked or not), `dout` is 0. Otherwise `dout` equals `din`. Muting starts in the cycle after the event that sets the bit.
- R7: After reset, status is 0, the mask is 7'h7F, mute is 0 and `alarm_o` is 0.
- R8: `rdata` returns the status (address 0), mask (address 1) and mute enable (address 2, bit 0), each zero-extended to 32 bits. Address 3 reads 0, and writes to address 3 change no register.
- R9: A status bit never becomes set without its event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| evt_i | input | 7 | One-cycle fault event pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 status, 1 mask, 2 control |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Combinational register read data |
| alarm_o | output | 1 | Registered active-high alarm pin |
| din | input | 16 | Incoming sample |
| dout | output | 16 | Outgoing sample, zero while muted |

## Verification
The properties take for granted that `evt_i`, `wr_en`, `addr` and `wdata` change only away from the rising edge and stay steady through it. They also assume an event may coincide with a clearing write or a mask write, since the R4 and R5 properties are written to allow that overlap. The mute property excludes a cycle in which software rewrites the control register, because the enable could drop at the same edge. The stimulus drives every input on the falling edge. It deliberately pairs events with clears and with mask changes, so that the combined cases appear at the edge in a defined order.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int unsigned NUM_SRC = 7;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd2;

  // Source bit positions inside the status and mask registers
  localparam int unsigned SRC_FIFO_EMPTY  = 0;
  localparam int unsigned SRC_FIFO_FULL   = 1;
  localparam int unsigned SRC_LINK_CLK    = 2;
  localparam int unsigned SRC_LINK_STROBE = 3;
  localparam int unsigned SRC_TRIG_REALGN = 4;
  localparam int unsigned SRC_CLK_REALGN  = 5;
  localparam int unsigned SRC_CLK_ALIGN   = 6;

  localparam int unsigned CTRL_MUTE_BIT = 0;
endpackage

// File: rtl/sticky_status_bank.sv
module sticky_status_bank #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] stat_q;
  logic [N-1:0] stat_d;
  logic [N-1:0] stat_en;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      stat_en[i] = evt_i[i] | clr_i[i];
      stat_d[i]  = evt_i[i];   // an event wins over a clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          stat_q[i] <= 1'b0;
      else if (stat_en[i]) stat_q[i] <= stat_d[i];
    end

    // R1
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[i] |=> stat_q[i]);
    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[i] && !clr_i[i]) |=> stat_q[i]);
    // R3
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !evt_i[i]) |=> !stat_q[i]);
    // R9
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_q[i] && !evt_i[i]) |=> !stat_q[i]);
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/alarm_pin_drive.sv
module alarm_pin_drive #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wd,
  input  logic [N-1:0] stat_i,
  output logic [N-1:0] mask_o,
  output logic         alarm_o
);
  logic [N-1:0] mask_q;
  logic         pin_q;
  logic         pin_d;

  always_comb begin
    pin_d = |(stat_i & ~mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_we) mask_q <= mask_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  // R5
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |=> !pin_q);
  // R5
  pin_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_q) |-> $past(|stat_i));

  assign mask_o  = mask_q;
  assign alarm_o = pin_q;
endmodule

// File: rtl/sample_mute_gate.sv
module sample_mute_gate #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic          ctrl_wd,
  input  logic          any_set,
  input  logic [DW-1:0] din,
  output logic          mute_en_o,
  output logic [DW-1:0] dout
);
  logic mute_q;
  logic hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mute_q <= 1'b0;
    else if (ctrl_we) mute_q <= ctrl_wd;
  end

  always_comb begin
    hold = mute_q & any_set;
    dout = hold ? '0 : din;
  end

  assign mute_en_o = mute_q;
endmodule

// File: rtl/alarm_status_ctrl.sv
module alarm_status_ctrl
  import alarm_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   rdata,
  output logic               alarm_o,
  input  logic [DATA_W-1:0]  din,
  output logic [DATA_W-1:0]  dout
);
  localparam int unsigned PAD_W = REG_W - NUM_SRC;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic               wr_stat;
  logic               wr_mask;
  logic               wr_ctrl;
  logic [NUM_SRC-1:0] clr_v;
  logic [NUM_SRC-1:0] stat_v;
  logic [NUM_SRC-1:0] mask_v;
  logic               mute_en;

  always_comb begin
    wr_stat = wr_en && (addr == ADDR_STATUS);
    wr_mask = wr_en && (addr == ADDR_MASK);
    wr_ctrl = wr_en && (addr == ADDR_CTRL);
    clr_v   = wr_stat ? wdata[NUM_SRC-1:0] : '0;
  end

  sticky_status_bank #(.N(NUM_SRC)) u_status (
    .clk    (clk),
    .rst_n  (rst_ni),
    .evt_i  (evt_i),
    .clr_i  (clr_v),
    .stat_o (stat_v)
  );

  alarm_pin_drive #(.N(NUM_SRC)) u_pin (
    .clk     (clk),
    .rst_n   (rst_ni),
    .mask_we (wr_mask),
    .mask_wd (wdata[NUM_SRC-1:0]),
    .stat_i  (stat_v),
    .mask_o  (mask_v),
    .alarm_o (alarm_o)
  );

  sample_mute_gate #(.DW(DATA_W)) u_mute (
    .clk       (clk),
    .rst_n     (rst_ni),
    .ctrl_we   (wr_ctrl),
    .ctrl_wd   (wdata[CTRL_MUTE_BIT]),
    .any_set   (|stat_v),
    .din       (din),
    .mute_en_o (mute_en),
    .dout      (dout)
  );

  always_comb begin
    unique case (addr)
      ADDR_STATUS: rdata = {{PAD_W{1'b0}}, stat_v};
      ADDR_MASK:   rdata = {{PAD_W{1'b0}}, mask_v};
      ADDR_CTRL:   rdata = {{(REG_W-1){1'b0}}, mute_en};
      default:     rdata = '0;
    endcase
  end

  // R6
  mute_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mute_en && (evt_i != '0) && !wr_ctrl) |=> (dout == '0));
  // R4
  evt_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ((evt_i & clr_v) != '0) |=> ((stat_v & $past(evt_i & clr_v)) == $past(evt_i & clr_v)));
endmodule

// File: tb/alarm_status_ctrl_test.sv
`timescale 1ns/1ps
module alarm_status_ctrl_test;
  localparam int unsigned NV = 16;
  localparam logic [15:0] DIN_PAT = 16'hA5C3;

  logic        clk;
  logic        rst_n;
  logic [6:0]  evt_i;
  logic        wr_en;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        alarm_o;
  logic [15:0] din;
  logic [15:0] dout;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  alarm_status_ctrl uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .alarm_o(alarm_o), .din(din), .dout(dout)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Row: evt(7) wr(1) addr(2) wdata(8) exp_status(7) exp_alarm(1) exp_mute(1)
  localparam logic [26:0] TBL [NV] = '{
    {7'h00, 1'b1, 2'd1, 8'h00, 7'h00, 1'b0, 1'b0},  // unmask all
    {7'h01, 1'b0, 2'd0, 8'h00, 7'h01, 1'b1, 1'b0},  // R1 event sets bit 0
    {7'h00, 1'b0, 2'd0, 8'h00, 7'h01, 1'b1, 1'b0},  // R2 sticky
    {7'h00, 1'b1, 2'd0, 8'h00, 7'h01, 1'b1, 1'b0},  // R3 zero write keeps bit
    {7'h00, 1'b1, 2'd0, 8'h01, 7'h00, 1'b0, 1'b0},  // R3 one clears
    {7'h44, 1'b1, 2'd0, 8'h04, 7'h44, 1'b1, 1'b0},  // R4 event beats clear
    {7'h00, 1'b1, 2'd1, 8'h7F, 7'h44, 1'b0, 1'b0},  // R5 full mask
    {7'h00, 1'b1, 2'd2, 8'h01, 7'h44, 1'b0, 1'b1},  // R6 masked bits still mute
    {7'h00, 1'b1, 2'd0, 8'h40, 7'h04, 1'b0, 1'b1},  // R6 partial clear stays muted
    {7'h00, 1'b1, 2'd0, 8'h7F, 7'h00, 1'b0, 1'b0},  // R6 all cleared resumes
    {7'h20, 1'b1, 2'd1, 8'h5F, 7'h20, 1'b1, 1'b1},  // R5 unmasked bit 5
    {7'h00, 1'b1, 2'd3, 8'hFF, 7'h20, 1'b1, 1'b1},  // R8 addr 3 write ignored
    {7'h10, 1'b0, 2'd0, 8'h00, 7'h30, 1'b1, 1'b1},  // R5 masked bit adds nothing
    {7'h08, 1'b1, 2'd0, 8'h30, 7'h08, 1'b0, 1'b1},  // R5 only masked bit left
    {7'h00, 1'b1, 2'd2, 8'h00, 7'h08, 1'b0, 1'b0},  // R6 mute off
    {7'h00, 1'b1, 2'd0, 8'h08, 7'h00, 1'b0, 1'b0}   // R3 final clear
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_read(input logic [1:0] a);
    evt_i = '0; wr_en = 1'b0; wdata = '0; addr = a;
  endtask

  initial begin
    #250000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; din = DIN_PAT;
    idle_read(2'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7 reset state, R8 read map
    #1;
    check("R7 status", rdata, 32'h0);
    check("R7 alarm", {31'b0, alarm_o}, 32'h0);
    addr = 2'd1; #1; check("R7 mask", rdata, 32'h7F);
    addr = 2'd2; #1; check("R7 mute", rdata, 32'h0);
    addr = 2'd3; #1; check("R8 addr3", rdata, 32'h0);
    check("R6 pass", {16'h0, dout}, {16'h0, DIN_PAT});

    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      v = TBL[i];
      @(negedge clk);
      evt_i = v[26:20]; wr_en = v[19]; addr = v[18:17]; wdata = {24'h0, v[16:9]};
      @(negedge clk);
      idle_read(2'd0);
      #1;
      check($sformatf("R1/R3 status row %0d", i), rdata, {25'h0, v[8:2]});
      check($sformatf("R6 dout row %0d", i), {16'h0, dout},
            {16'h0, (v[0] ? 16'h0 : DIN_PAT)});
      @(negedge clk);
      #1;
      check($sformatf("R5 alarm row %0d", i), {31'b0, alarm_o}, {31'b0, v[1]});
    end

    // R8 register readback after the table
    addr = 2'd1; #1; check("R8 mask readback", rdata, 32'h5F);
    addr = 2'd2; #1; check("R8 ctrl readback", rdata, 32'h0);

    // R5 pin lags status by one cycle
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd1; wdata = 32'h0;
    @(negedge clk);
    idle_read(2'd0); evt_i = 7'h04;
    @(negedge clk);
    idle_read(2'd0); #1;
    check("R1 bit2 set", rdata, 32'h04);
    check("R5 pin not yet", {31'b0, alarm_o}, 32'h0);
    @(negedge clk); #1;
    check("R5 pin raised", {31'b0, alarm_o}, 32'h1);

    // R6 mute starts the cycle after the event
    wr_en = 1'b1; addr = 2'd0; wdata = 32'h7F;
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd2; wdata = 32'h1;
    @(negedge clk);
    idle_read(2'd0); evt_i = 7'h02; #1;
    check("R6 not muted before edge", {16'h0, dout}, {16'h0, DIN_PAT});
    @(negedge clk);
    idle_read(2'd0); #1;
    check("R6 muted after edge", {16'h0, dout}, 32'h0);
    din = 16'h1234; #1;
    check("R6 still zero new din", {16'h0, dout}, 32'h0);

    // R7 reset mid-run restores defaults
    rst_n = 1'b0; #1;
    check("R7 async status", rdata, 32'h0);
    addr = 2'd1; #1; check("R7 async mask", rdata, 32'h7F);
    check("R7 dout passes", {16'h0, dout}, 32'h1234);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule